// File: doc/BRIEF.md
# Link Packet Word Formatter

This block assembles one link packet word on each pixel-clock strobe. It takes the parallel video lane bits and places them in a word ahead of scrambling and line coding. It works in two widths. In the narrow mode three lanes of payload give a 24-bit packet. In the wide mode four lanes, plus one extra control position, give a 32-bit packet. After the payload come an audio side-channel bit and a forward control-channel bit. An even-parity check bit closes the packet.

In wide mode a remap flag replaces the topmost lane bit, the normally reserved position, with a control input. The packet is registered and reported with a one-cycle valid strobe and its effective length. The mode and the remap flag are sampled together with the data on each strobe. A mode change therefore applies to whole packets only.

Top module: `link_pkt_fmt`

## Requirements
- R1: In narrow mode (`quad_mode`=0) the packet is: bits 0..20 = `lane_data[20:0]`, bit 21 = `aud_bit`, bit 22 = `fwd_bit`, bit 23 = parity.
- R2: In wide mode (`quad_mode`=1) with `res_remap`=0 the packet is: bits 0..27 = `lane_data[27:0]`, bit 28 = `ctl_ext`, bit 29 = `aud_bit`, bit 30 = `fwd_bit`, bit 31 = parity.
- R3: The parity bit is even parity, so the XOR of every bit of the packet, the parity bit included, is zero.
- R4: In wide mode with `res_remap`=1, bit 27 carries `ctl_res` in place of `lane_data[27]`. All other bits follow R2.
- R5: In narrow mode, bits 24..31 of `pkt_word` are zero. `res_remap`, `ctl_res`, `ctl_ext` and `lane_data[27:21]` have no effect on the output.
- R6: `pkt_len` reads 24 for a narrow packet and 32 for a wide packet.
- R7: `pkt_vld` is high exactly one cycle after a cycle with `in_stb`=1, and low otherwise. Reset clears `pkt_vld`, `pkt_word` and `pkt_len` to zero.
- R8: In a cycle without `in_stb`, `pkt_word` and `pkt_len` hold their values whatever the other inputs do.
- R9: The mode is taken from the strobe cycle of each packet. Back-to-back strobes with alternating modes give packets that each follow their own mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_stb | input | 1 | Capture strobe for the current input set |
| quad_mode | input | 1 | 1 = four-lane packet, 0 = three-lane packet |
| res_remap | input | 1 | Wide mode: put `ctl_res` in the reserved position |
| ctl_res | input | 1 | Control bit that may replace the reserved bit |
| ctl_ext | input | 1 | Control bit in the extra wide-mode position |
| aud_bit | input | 1 | Audio side-channel bit |
| fwd_bit | input | 1 | Forward control-channel bit |
| lane_data | input | 28 | Lane payload bits, lane-major |
| pkt_word | output | 32 | Registered packet word, upper bits zero in narrow mode |
| pkt_len | output | 6 | Effective packet length in bits |
| pkt_vld | output | 1 | Packet valid strobe |

## Verification
Two things can meet in one cycle: a mode switch and the strobe that captures a packet, and in the narrow case also an asserted remap flag. The bench sweeps all 64 combinations of the mode, remap and single-bit inputs. The low combination bit selects the mode, so consecutive strobes alternate between narrow and wide packets with no idle cycle between them. Each packet is compared with a word built arithmetically from its own inputs. A packet that takes any field from the neighbouring packet's mode, or that lets the remap flag act in narrow mode, fails the comparison. Idle cycles with scrambled inputs are placed between bursts to show that the held word and length do not move.

// File: rtl/link_pkt_fmt.sv
module link_pkt_fmt #(
  parameter int LANE_W = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_stb,
  input  logic                  quad_mode,
  input  logic                  res_remap,
  input  logic                  ctl_res,
  input  logic                  ctl_ext,
  input  logic                  aud_bit,
  input  logic                  fwd_bit,
  input  logic [4*LANE_W-1:0]   lane_data,
  output logic [4*LANE_W+3:0]   pkt_word,
  output logic [$clog2(4*LANE_W+5)-1:0] pkt_len,
  output logic                  pkt_vld
);
  localparam int DATA_W = 4 * LANE_W;
  localparam int PAY3   = 3 * LANE_W;
  localparam int PAY4   = DATA_W + 1;
  localparam int PKT3   = PAY3 + 3;
  localparam int PKT4   = PAY4 + 3;
  localparam int LEN_W  = $clog2(PKT4 + 1);

  logic [PKT4-1:0] nxt;

  always_comb begin
    nxt = '0;
    if (quad_mode) begin
      nxt[DATA_W-1:0] = lane_data;
      if (res_remap) nxt[DATA_W-1] = ctl_res;
      nxt[DATA_W]     = ctl_ext;
      nxt[PAY4]       = aud_bit;
      nxt[PAY4+1]     = fwd_bit;
      nxt[PAY4+2]     = ^nxt[PAY4+1:0];
    end else begin
      nxt[PAY3-1:0]   = lane_data[PAY3-1:0];
      nxt[PAY3]       = aud_bit;
      nxt[PAY3+1]     = fwd_bit;
      nxt[PAY3+2]     = ^nxt[PAY3+1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pkt_word <= '0;
      pkt_len  <= '0;
      pkt_vld  <= 1'b0;
    end else begin
      pkt_vld <= in_stb;
      if (in_stb) begin
        pkt_word <= nxt;
        pkt_len  <= quad_mode ? LEN_W'(PKT4) : LEN_W'(PKT3);
      end
    end
  end
endmodule

module link_pkt_fmt_chk #(
  parameter int LANE_W = 7
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_stb,
  input logic                  quad_mode,
  input logic                  res_remap,
  input logic                  ctl_res,
  input logic                  aud_bit,
  input logic [4*LANE_W+3:0]   pkt_word,
  input logic [$clog2(4*LANE_W+5)-1:0] pkt_len
  , input logic                pkt_vld
);
  localparam int DATA_W = 4 * LANE_W;
  localparam int PKT3   = 3 * LANE_W + 3;
  localparam int PKT4   = DATA_W + 4;

  a_r7_vld_follows_stb: assert property (@(posedge clk) disable iff (!rst_n)
    in_stb |=> pkt_vld);
  a_r7_no_spurious_vld: assert property (@(posedge clk) disable iff (!rst_n)
    !in_stb |=> !pkt_vld);
  a_r3_even_parity: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_vld |-> (^pkt_word) == 1'b0);
  a_r6_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_vld |-> (int'(pkt_len) == PKT3 || int'(pkt_len) == PKT4));
  a_r5_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_vld && int'(pkt_len) == PKT3) |-> pkt_word[PKT4-1:PKT3] == '0);
  a_r9_mode_per_packet: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stb && !quad_mode) |=> int'(pkt_len) == PKT3);
  a_r2_wide_audio_pos: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stb && quad_mode) |=> pkt_word[DATA_W+1] == $past(aud_bit));
  a_r4_remap_pos: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stb && quad_mode && res_remap) |=> pkt_word[DATA_W-1] == $past(ctl_res));
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_stb && $past(rst_n)) |=> ($stable(pkt_word) && $stable(pkt_len)));
endmodule

bind link_pkt_fmt link_pkt_fmt_chk #(.LANE_W(LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_stb(in_stb), .quad_mode(quad_mode),
  .res_remap(res_remap), .ctl_res(ctl_res), .aud_bit(aud_bit),
  .pkt_word(pkt_word), .pkt_len(pkt_len), .pkt_vld(pkt_vld)
);

// File: tb/link_pkt_fmt_test.sv
`timescale 1ns/1ps
module link_pkt_fmt_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_stb = 1'b0, quad_mode = 1'b0, res_remap = 1'b0;
  logic ctl_res = 1'b0, ctl_ext = 1'b0, aud_bit = 1'b0, fwd_bit = 1'b0;
  logic [27:0] lane_data = '0;
  logic [31:0] pkt_word;
  logic [5:0]  pkt_len;
  logic        pkt_vld;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] lcg = 32'h1234_5678;

  always #4 clk = ~clk;

  link_pkt_fmt uut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_word(input logic q, rm, cr, ce, a, f, input logic [27:0] d);
    logic [31:0] w;
    int n;
    w = 0;
    if (q) begin
      w = {4'b0, d};
      if (rm) w[27] = cr;
      w[28] = ce; w[29] = a; w[30] = f; n = 31;
    end else begin
      w = {11'b0, d[20:0]};
      w[21] = a; w[22] = f; n = 23;
    end
    for (int i = 0; i < n; i++) w[n] = w[n] ^ w[i];
    return w;
  endfunction

  task automatic send(input logic q, rm, cr, ce, a, f, input logic [27:0] d, input logic prevq);
    logic [31:0] e;
    in_stb = 1; quad_mode = q; res_remap = rm; ctl_res = cr; ctl_ext = ce;
    aud_bit = a; fwd_bit = f; lane_data = d;
    e = expect_word(q, rm, cr, ce, a, f, d);
    @(posedge clk); @(negedge clk);
    in_stb = 0;
    if (!q) chk(pkt_word == e, rm ? "R5 narrow remap ignored" : "R1 narrow layout", pkt_word, e);
    else chk(pkt_word == e, rm ? "R4 remap layout" : "R2 wide layout", pkt_word, e);
    chk((^pkt_word) == 1'b0, "R3 even parity", {31'b0, ^pkt_word}, 32'd0);
    chk(pkt_len == (q ? 6'd32 : 6'd24), "R6 length", {26'b0, pkt_len}, q ? 32'd32 : 32'd24);
    chk(pkt_vld == 1'b1, "R7 valid after strobe", {31'b0, pkt_vld}, 32'd1);
    if (q != prevq) chk(pkt_len == (q ? 6'd32 : 6'd24), "R9 mode switch per packet", {26'b0, pkt_len}, q ? 32'd32 : 32'd24);
  endtask

  task automatic idle();
    logic [31:0] w0;
    logic [5:0]  l0;
    w0 = pkt_word; l0 = pkt_len;
    in_stb = 0; quad_mode = ~quad_mode; res_remap = ~res_remap; ctl_res = ~ctl_res;
    ctl_ext = ~ctl_ext; aud_bit = ~aud_bit; fwd_bit = ~fwd_bit; lane_data = ~lane_data;
    @(posedge clk); @(negedge clk);
    chk(pkt_vld == 1'b0, "R7 no valid without strobe", {31'b0, pkt_vld}, 32'd0);
    chk(pkt_word == w0, "R8 word holds", pkt_word, w0);
    chk(pkt_len == l0, "R8 length holds", {26'b0, pkt_len}, {26'b0, l0});
  endtask

  initial begin
    logic prevq;
    repeat (3) @(negedge clk);
    chk(pkt_vld == 0, "R7 reset valid", {31'b0, pkt_vld}, 0);
    chk(pkt_word == 0, "R7 reset word", pkt_word, 0);
    chk(pkt_len == 0, "R7 reset length", {26'b0, pkt_len}, 0);
    rst_n = 1;
    @(negedge clk);
    prevq = 0;
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 64; c++) begin
        logic [27:0] d;
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        d = (p == 0) ? 28'h0 : (p == 1) ? 28'hFFFFFFF : (p == 2) ? 28'h5555555 : lcg[31:4];
        send(c[0], c[1], c[2], c[3], c[4], c[5], d, prevq);
        prevq = c[0];
        if (c % 8 == 7) idle();
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule